// File: doc/BRIEF.md
# Paged Far-Call Sequencer

This block runs far subroutine calls and far returns for a small CPU whose 64 KB local map holds a 16 KB program window. An 8-bit page register selects which of 256 program pages shows through the window. A far call saves the 16-bit return address and the outgoing page on a byte-wide memory stack, switches page and jumps. A far return undoes this in reverse. While either sequence runs, `busy` is high so the CPU holds off interrupts. Instruction decode and the prefetch queue are outside the block. The block only raises a refill request when it loads the PC.

The window sits at local addresses 0x8000–0xBFFF. A combinational translator turns any local address into a 23-bit physical address. Inside the window the result is `{1'b1, page, addr[13:0]}`. Outside it, the result is `{7'b0, addr}`. The top bit therefore marks a paged access.

The controller has these states: IDLE; RD_AH, RD_AL, RD_PG (indirect operand fetch); SWAP; PUSH_L, PUSH_H, PUSH_P; PULL_P, PULL_H, PULL_L; SET_PG; JUMP.
The transitions are:
- IDLE→RD_AH on an indirect call, and IDLE→SWAP on a direct call.
- IDLE→PULL_P on a return.
- RD_AH→RD_AL→RD_PG→SWAP→PUSH_L→PUSH_H→PUSH_P→JUMP.
- PULL_P→PULL_H→PULL_L→SET_PG→JUMP.
- JUMP→IDLE.

Top module: `farcall_seq`

## Requirements
- R1: After reset, page_out is 0x00, and busy, mem_req, pc_load, refill_req and sp_wr are all 0.
- R2: A direct call (call_go with ind_mode=0) loads page_out with tgt_page. It then gives pc_out=tgt_addr in the cycle where pc_load and refill_req pulse. busy is high for exactly 5 cycles.
- R3: A call writes three bytes, in this cycle order: ret_addr[7:0] at SP-1, ret_addr[15:8] at SP-2, and the old page at SP-3. In the final cycle it reports sp_out=SP-3 with sp_wr.
- R4: An indirect call reads ptr+0 (target address high byte), ptr+1 (low byte) and ptr+2 (new page), in that order, before any push. It ignores tgt_page and tgt_addr, and busy is high for 8 cycles.
- R5: A return reads the page from SP, then the address high byte from SP+1, then the low byte from SP+2. It reports pc_out equal to that address, sp_out=SP+3, and busy high for 5 cycles.
- R6: During a call, page_out already holds the new page at the first stack write. During a return, page_out keeps the old page through all three pulls and holds the restored page by the pc_load cycle. While idle, page_out does not change.
- R7: busy rises the cycle after an accepted command and stays high through the pc_load cycle. call_go or rtc_go raised while busy has no effect.
- R8: Local addresses 0x8000–0xBFFF translate to {1, page, addr[13:0]}. All other addresses translate to {7'b0, addr}.
- R9: Nested calls followed by matching returns restore each page and PC in reverse order and leave the stack pointer where it began.
- R10: If call_go and rtc_go are both high in IDLE, the call is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_go | input | 1 | Far call command strobe |
| rtc_go | input | 1 | Far return command strobe |
| ind_mode | input | 1 | Call takes its page and target from memory through ptr_addr |
| tgt_page | input | 8 | Immediate new page for a direct call |
| tgt_addr | input | 16 | Immediate target address for a direct call |
| ret_addr | input | 16 | Address of the instruction after the call |
| ptr_addr | input | 16 | Operand pointer for an indirect call |
| sp_in | input | 16 | Stack pointer at command time |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| sp_out | output | 16 | Updated stack pointer, valid with sp_wr |
| sp_wr | output | 1 | Stack pointer update strobe |
| pc_out | output | 16 | New PC, valid with pc_load |
| pc_load | output | 1 | PC load strobe |
| refill_req | output | 1 | Prefetch queue refill request |
| page_out | output | 8 | Current program page |
| busy | output | 1 | Sequence running, interrupts held off |
| loc_addr | input | 16 | Local address to translate |
| phys_addr | output | 23 | Translated physical address |

## Verification
A command strobe is sampled on one edge, and busy is visible from the next cycle. The memory strobes, page_out and the final pc_load/sp_wr pulse then follow one state per cycle. The final pulse falls on the 5th busy cycle for a direct call or a return, and on the 8th for an indirect call. The bench drives inputs on falling edges and samples outputs on falling edges. It logs every request in arrival order, so order and cycle count are both compared against values that the bench's own stack model computes. Translation is combinational, so it is checked shortly after loc_addr changes.

// File: rtl/farcall_pkg.sv
package farcall_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_AH,
        S_RD_AL,
        S_RD_PG,
        S_SWAP,
        S_PUSH_L,
        S_PUSH_H,
        S_PUSH_P,
        S_PULL_P,
        S_PULL_H,
        S_PULL_L,
        S_SET_PG,
        S_JUMP
    } seq_state_t;
endpackage

// File: rtl/page_xlate.sv
module page_xlate #(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int WIN_W   = 14,
    parameter int WIN_SEL = 2
) (
    input  logic [ADDR_W-1:0]          loc_addr,
    input  logic [PAGE_W-1:0]          page,
    output logic [PAGE_W+WIN_W:0]      phys_addr
);
    localparam int PHYS_W = PAGE_W + WIN_W + 1;
    localparam int SEL_W  = ADDR_W - WIN_W;

    logic in_win;

    always_comb begin
        in_win = (loc_addr[ADDR_W-1:WIN_W] == SEL_W'(WIN_SEL));
        if (in_win)
            phys_addr = {1'b1, page, loc_addr[WIN_W-1:0]};
        else
            phys_addr = PHYS_W'(loc_addr);
    end

    // R8
    always_comb begin
        win_flag_chk: assert ((loc_addr >= ADDR_W'(WIN_SEL << WIN_W)) &&
                              (loc_addr <  ADDR_W'((WIN_SEL + 1) << WIN_W))
                              ? phys_addr[PHYS_W-1] : (phys_addr[ADDR_W-1:0] == loc_addr));
    end
endmodule

// File: rtl/farcall_ctrl.sv
module farcall_ctrl
    import farcall_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_go,
    input  logic              rtc_go,
    input  logic              ind_mode,
    input  logic [PAGE_W-1:0] tgt_page,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [7:0]        mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] sp_out,
    output logic              sp_wr,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_load,
    output logic              refill_req,
    output logic [PAGE_W-1:0] page_q,
    output logic              busy
);
    localparam int HB = ADDR_W / 2;

    seq_state_t        state, nxt;
    logic [PAGE_W-1:0] tmp_pg, new_pg;
    logic [ADDR_W-1:0] addr_r, ret_r, sp_r, ptr_r;
    logic              dir_call;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (call_go)     nxt = ind_mode ? S_RD_AH : S_SWAP;
                else if (rtc_go) nxt = S_PULL_P;
            end
            S_RD_AH:  nxt = S_RD_AL;
            S_RD_AL:  nxt = S_RD_PG;
            S_RD_PG:  nxt = S_SWAP;
            S_SWAP:   nxt = S_PUSH_L;
            S_PUSH_L: nxt = S_PUSH_H;
            S_PUSH_H: nxt = S_PUSH_P;
            S_PUSH_P: nxt = S_JUMP;
            S_PULL_P: nxt = S_PULL_H;
            S_PULL_H: nxt = S_PULL_L;
            S_PULL_L: nxt = S_SET_PG;
            S_SET_PG: nxt = S_JUMP;
            S_JUMP:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q   <= '0;
            tmp_pg   <= '0;
            new_pg   <= '0;
            addr_r   <= '0;
            ret_r    <= '0;
            sp_r     <= '0;
            ptr_r    <= '0;
            dir_call <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (call_go) begin
                        new_pg   <= tgt_page;
                        addr_r   <= tgt_addr;
                        ret_r    <= ret_addr;
                        ptr_r    <= ptr_addr;
                        sp_r     <= sp_in;
                        dir_call <= 1'b1;
                    end else if (rtc_go) begin
                        sp_r     <= sp_in;
                        dir_call <= 1'b0;
                    end
                end
                S_RD_AH:  addr_r[ADDR_W-1:HB] <= mem_rdata;
                S_RD_AL:  addr_r[HB-1:0]      <= mem_rdata;
                S_RD_PG:  new_pg              <= mem_rdata;
                S_SWAP: begin
                    tmp_pg <= page_q;
                    page_q <= new_pg;
                end
                S_PULL_P: tmp_pg              <= mem_rdata;
                S_PULL_H: addr_r[ADDR_W-1:HB] <= mem_rdata;
                S_PULL_L: addr_r[HB-1:0]      <= mem_rdata;
                S_SET_PG: page_q              <= tmp_pg;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        sp_wr      = 1'b0;
        pc_load    = 1'b0;
        refill_req = 1'b0;
        sp_out     = dir_call ? sp_r - ADDR_W'(3) : sp_r + ADDR_W'(3);
        pc_out     = addr_r;
        busy       = (state != S_IDLE);
        unique case (state)
            S_RD_AH:  begin mem_req = 1'b1; mem_addr = ptr_r; end
            S_RD_AL:  begin mem_req = 1'b1; mem_addr = ptr_r + ADDR_W'(1); end
            S_RD_PG:  begin mem_req = 1'b1; mem_addr = ptr_r + ADDR_W'(2); end
            S_PUSH_L: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp_r - ADDR_W'(1); mem_wdata = ret_r[HB-1:0];
            end
            S_PUSH_H: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp_r - ADDR_W'(2); mem_wdata = ret_r[ADDR_W-1:HB];
            end
            S_PUSH_P: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp_r - ADDR_W'(3); mem_wdata = 8'(tmp_pg);
            end
            S_PULL_P: begin mem_req = 1'b1; mem_addr = sp_r; end
            S_PULL_H: begin mem_req = 1'b1; mem_addr = sp_r + ADDR_W'(1); end
            S_PULL_L: begin mem_req = 1'b1; mem_addr = sp_r + ADDR_W'(2); end
            S_JUMP: begin
                sp_wr = 1'b1; pc_load = 1'b1; refill_req = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pc_load |=> busy);
    // R7
    start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(call_go || rtc_go));
    // R6
    page_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(page_q));
    // R3
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && busy && !pc_load));
    // R2
    sp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |=> !busy);
endmodule

// File: rtl/farcall_seq.sv
module farcall_seq #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter int WIN_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    call_go,
    input  logic                    rtc_go,
    input  logic                    ind_mode,
    input  logic [PAGE_W-1:0]       tgt_page,
    input  logic [ADDR_W-1:0]       tgt_addr,
    input  logic [ADDR_W-1:0]       ret_addr,
    input  logic [ADDR_W-1:0]       ptr_addr,
    input  logic [ADDR_W-1:0]       sp_in,
    input  logic [7:0]              mem_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    output logic [ADDR_W-1:0]       sp_out,
    output logic                    sp_wr,
    output logic [ADDR_W-1:0]       pc_out,
    output logic                    pc_load,
    output logic                    refill_req,
    output logic [PAGE_W-1:0]       page_out,
    output logic                    busy,
    input  logic [ADDR_W-1:0]       loc_addr,
    output logic [PAGE_W+WIN_W:0]   phys_addr
);
    localparam int WIN_SEL = 2;

    farcall_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_go    (call_go),
        .rtc_go     (rtc_go),
        .ind_mode   (ind_mode),
        .tgt_page   (tgt_page),
        .tgt_addr   (tgt_addr),
        .ret_addr   (ret_addr),
        .ptr_addr   (ptr_addr),
        .sp_in      (sp_in),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .sp_out     (sp_out),
        .sp_wr      (sp_wr),
        .pc_out     (pc_out),
        .pc_load    (pc_load),
        .refill_req (refill_req),
        .page_q     (page_out),
        .busy       (busy)
    );

    page_xlate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .WIN_SEL(WIN_SEL)) u_xlate (
        .loc_addr  (loc_addr),
        .page      (page_out),
        .phys_addr (phys_addr)
    );
endmodule

// File: tb/test_farcall_seq.sv
module test_farcall_seq;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_go = 0, rtc_go = 0, ind_mode = 0;
    logic [7:0]  tgt_page = 0;
    logic [15:0] tgt_addr = 0, ret_addr = 0, ptr_addr = 0, sp_in = 0, loc_addr = 0;
    logic [7:0]  mem_rdata;
    logic        mem_req, mem_we, sp_wr, pc_load, refill_req, busy;
    logic [15:0] mem_addr, sp_out, pc_out;
    logic [7:0]  mem_wdata, page_out;
    logic [22:0] phys_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mem [0:255];

    always #(CLK_PER/2) clk = ~clk;

    farcall_seq i_farcall_seq (
        .clk(clk), .rst_n(rst_n), .call_go(call_go), .rtc_go(rtc_go),
        .ind_mode(ind_mode), .tgt_page(tgt_page), .tgt_addr(tgt_addr),
        .ret_addr(ret_addr), .ptr_addr(ptr_addr), .sp_in(sp_in),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_out(sp_out),
        .sp_wr(sp_wr), .pc_out(pc_out), .pc_load(pc_load),
        .refill_req(refill_req), .page_out(page_out), .busy(busy),
        .loc_addr(loc_addr), .phys_addr(phys_addr)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    // bench stack model
    logic [7:0]  m_pg [0:7];
    logic [15:0] m_pc [0:7];
    int          depth = 0;
    logic [7:0]  cur_pg = 0;
    logic [15:0] sp_m = 16'h00F0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // op: 1 call, 0 return; both: raise both strobes; poke: strobe mid-sequence
    task automatic run_cmd(input bit op, input bit ind, input logic [7:0] pg,
                           input logic [15:0] ta, input logic [15:0] ra,
                           input bit both, input bit poke, input string rq);
        logic [7:0]  exp_pg, old_pg, pg_at_wr, pg_at_rd;
        logic [15:0] exp_pc, sp0, exp_sp;
        logic [47:0] rd_log, wr_log, exp_rd, exp_wr;
        logic [23:0] wd_log;
        int nb, nr, nw;
        bit seen;
        sp0 = sp_m; old_pg = cur_pg;
        rd_log = '0; wr_log = '0; wd_log = '0; nb = 0; nr = 0; nw = 0; seen = 0;
        pg_at_wr = 8'hxx; pg_at_rd = 8'hxx;
        if (op) begin
            exp_pg = ind ? mem[8'h42] : pg;
            exp_pc = ind ? {mem[8'h40], mem[8'h41]} : ta;
            m_pg[depth] = cur_pg; m_pc[depth] = ra; depth++;
            exp_sp = sp0 - 16'd3;
        end else begin
            depth--;
            exp_pg = m_pg[depth]; exp_pc = m_pc[depth];
            exp_sp = sp0 + 16'd3;
        end
        @(negedge clk);
        call_go = op; rtc_go = !op || both; ind_mode = ind;
        tgt_page = pg; tgt_addr = ta; ret_addr = ra; ptr_addr = 16'h0040; sp_in = sp0;
        @(negedge clk);
        call_go = 0; rtc_go = 0;
        for (int k = 0; k < 20; k++) begin
            call_go = 0; rtc_go = 0;
            if (busy) nb++;
            if (mem_req && !mem_we) begin
                rd_log = {rd_log[31:0], mem_addr}; nr++;
                if (nr == 1) pg_at_rd = page_out;
            end
            if (mem_req && mem_we) begin
                wr_log = {wr_log[31:0], mem_addr}; wd_log = {wd_log[15:0], mem_wdata}; nw++;
                if (nw == 1) pg_at_wr = page_out;
            end
            if (pc_load) begin
                seen = 1;
                chk(pc_out == exp_pc, rq, "pc_out", 64'(pc_out), 64'(exp_pc));
                chk(page_out == exp_pg, rq, "page at pc_load (R6)", 64'(page_out), 64'(exp_pg));
                chk(sp_wr && sp_out == exp_sp, rq, "sp_out (R3/R5)", 64'(sp_out), 64'(exp_sp));
                chk(refill_req, rq, "refill_req", 64'(refill_req), 64'd1);
                break;
            end
            if (poke && k == 1) begin call_go = 1; rtc_go = 1; end
            @(negedge clk);
        end
        call_go = 0; rtc_go = 0;
        chk(seen, rq, "pc_load seen", 64'(seen), 64'd1);
        chk(nb == (op ? (ind ? 8 : 5) : 5), rq, "busy cycles (R7)", 64'(nb), 64'(op ? (ind ? 8 : 5) : 5));
        if (op) begin
            exp_wr = {sp0 - 16'd1, sp0 - 16'd2, sp0 - 16'd3};
            chk(nw == 3 && wr_log == exp_wr, "R3", "push order", 64'(wr_log), 64'(exp_wr));
            chk(wd_log == {ra[7:0], ra[15:8], old_pg}, "R3", "push data", 64'(wd_log),
                64'({ra[7:0], ra[15:8], old_pg}));
            chk(pg_at_wr == exp_pg, "R6", "page at first push", 64'(pg_at_wr), 64'(exp_pg));
            exp_rd = {16'h0040, 16'h0041, 16'h0042};
            if (ind) chk(nr == 3 && rd_log == exp_rd, "R4", "operand reads", 64'(rd_log), 64'(exp_rd));
            else     chk(nr == 0, "R2", "no reads", 64'(nr), 64'd0);
        end else begin
            exp_rd = {sp0, sp0 + 16'd1, sp0 + 16'd2};
            chk(nr == 3 && nw == 0 && rd_log == exp_rd, "R5", "pull order", 64'(rd_log), 64'(exp_rd));
            chk(pg_at_rd == old_pg, "R6", "page during pulls", 64'(pg_at_rd), 64'(old_pg));
        end
        cur_pg = exp_pg; sp_m = exp_sp;
        @(negedge clk);
        chk(!busy, rq, "idle after sequence (R7)", 64'(busy), 64'd0);
        repeat (2) @(negedge clk);
        chk(!busy && page_out == cur_pg, rq, "no restart/page hold (R7)", 64'({busy, page_out}),
            64'({1'b0, cur_pg}));
    endtask

    task automatic xl(input logic [15:0] a, input logic [22:0] e);
        loc_addr = a; #1;
        chk(phys_addr == e, "R8", "translate", 64'(phys_addr), 64'(e));
    endtask

    // {op, ind, page, target, return}
    typedef struct packed {
        logic        op;
        logic        ind;
        logic [7:0]  pg;
        logic [15:0] ta;
        logic [15:0] ra;
    } vec_t;
    localparam vec_t VEC [6] = '{
        '{1'b1, 1'b0, 8'h12, 16'h8100, 16'h4003},   // R2 outer call
        '{1'b1, 1'b0, 8'h34, 16'h9ABC, 16'h8105},   // R9 nested call
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000},   // R9 inner return
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000},   // R9 outer return
        '{1'b1, 1'b1, 8'hEE, 16'h1111, 16'hC010},   // R4 indirect, immediates ignored
        '{1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000}    // R5 return
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h40] = 8'hA5; mem[8'h41] = 8'h5A; mem[8'h42] = 8'h7E;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(page_out == 8'h00 && !busy && !mem_req && !pc_load && !refill_req && !sp_wr,
            "R1", "reset outputs", 64'({page_out, busy, mem_req, pc_load, refill_req, sp_wr}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(page_out == 8'h00 && !busy, "R1", "after release", 64'({page_out, busy}), 64'd0);
        xl(16'h8000, 23'h400000);   // R8 page 0 window
        for (int v = 0; v < 6; v++)
            run_cmd(VEC[v].op, VEC[v].ind, VEC[v].pg, VEC[v].ta, VEC[v].ra, 0, 0, "R9");
        chk(sp_m == 16'h00F0 && depth == 0, "R9", "stack balanced", 64'(sp_m), 64'h00F0);
        // R7 strobes while busy are ignored
        run_cmd(1, 0, 8'hC3, 16'hA000, 16'h0123, 0, 1, "R7");
        // R8 translation with page C3
        xl(16'h8000, {1'b1, 8'hC3, 14'h0000});
        xl(16'hBFFF, {1'b1, 8'hC3, 14'h3FFF});
        xl(16'h7FFF, 23'h007FFF);
        xl(16'hC000, 23'h00C000);
        run_cmd(0, 0, 8'h00, 16'h0000, 16'h0000, 0, 1, "R7");
        // R10 both strobes: call wins
        run_cmd(1, 0, 8'h5C, 16'hB00B, 16'h2222, 1, 0, "R10");
        run_cmd(0, 0, 8'h00, 16'h0000, 16'h0000, 0, 0, "R5");
        chk(page_out == 8'h00, "R9", "final page", 64'(page_out), 64'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule